// File: doc/BRIEF.md
# Parallel ADC read sequencer

This block is a synchronous controller between a host request line and an external 12-bit successive-approximation converter that has a parallel data bus. A request pulse starts one transaction. The controller first drives a write strobe to start a conversion. It then waits for the conversion to finish. Finally it fetches the result with one or two read strobes and presents the assembled 12-bit sample together with a one-cycle valid strobe and a one-cycle interrupt pulse.

There are two ways to detect the end of a conversion. In status mode the controller watches the converter's busy status line. A watchdog ends a transaction whose status never falls. In timeout mode the controller ignores the status line and waits a fixed count that covers the longest conversion.

There are also two bus widths. In 16-bit mode a single read returns the whole sample, which sits either in the upper or in the lower twelve lines of the bus. In 8-bit mode the controller makes two byte reads, selected by an address line, and joins the two parts. The three mode inputs are captured when a request is accepted.

Top module: `adc_rd_seq`

## Requirements
- R1: When idle, a high `req_i` starts one transaction. The controller asserts `cs_o` and `wr_o` together, with `rd_o` low, for exactly STROBE_CLKS consecutive cycles. `busy_o` is high from the cycle after the request until the cycle after the done pulse.
- R2: In status mode (`tmo_mode_i`=0), reads begin only after `status_i` has been seen high during the wait and then seen low. No read strobe is driven while `status_i` is high.
- R3: In timeout mode (`tmo_mode_i`=1), the wait between the last write-strobe cycle and the first read-strobe cycle lasts exactly CLK_MHZ*CONV_US+1 cycles, which is 1251 at the defaults, whatever `status_i` does.
- R4: In status mode, if `status_i` has not fallen after 2*CLK_MHZ*CONV_US wait cycles (2500 at the defaults), `err_o` pulses for one cycle. No read and no valid pulse follow, and the controller returns to idle.
- R5: In 16-bit mode (`bus8_i`=0) there is a single read with `a0_o`=0. With `align_hi_i`=1 the sample is `bus_d_i[15:4]`; with `align_hi_i`=0 it is `bus_d_i[11:0]`. The other four lines have no effect on the sample.
- R6: In 8-bit mode (`bus8_i`=1) there are two reads. The first, with `a0_o`=0, supplies sample bits 11..4 from `bus_d_i[7:0]`. The second, with `a0_o`=1, supplies sample bits 3..0 from `bus_d_i[7:4]`. Lines 15..8 and 3..0 of the second read are ignored, and so are lines 15..8 of the first.
- R7: Each read asserts `cs_o` and `rd_o` together, with `wr_o` low, for exactly STROBE_CLKS cycles.
- R8: At completion, `valid_o` and `irq_o` are high together for exactly one cycle. `sample_o` holds the new sample from that cycle until the next completion.
- R9: A `req_i` that arrives while `busy_o` is high is ignored and starts no further conversion.
- R10: After reset, `cs_o`, `wr_o`, `rd_o`, `busy_o`, `valid_o`, `irq_o` and `err_o` are low and `sample_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request for one sample |
| tmo_mode_i | input | 1 | 1: fixed timeout, 0: watch status |
| bus8_i | input | 1 | 1: 8-bit bus with two reads, 0: 16-bit bus |
| align_hi_i | input | 1 | 16-bit mode: sample on upper twelve lines |
| status_i | input | 1 | Converter busy status, high while converting |
| bus_d_i | input | 16 | Converter data bus |
| cs_o | output | 1 | Converter chip select |
| wr_o | output | 1 | Conversion start write strobe |
| rd_o | output | 1 | Data read strobe |
| a0_o | output | 1 | Byte select for 8-bit reads |
| sample_o | output | 12 | Assembled sample |
| valid_o | output | 1 | One-cycle sample valid strobe |
| irq_o | output | 1 | One-cycle done interrupt |
| busy_o | output | 1 | Transaction in progress |
| err_o | output | 1 | One-cycle watchdog error pulse |

## Verification
The bound checker watches the strobe rules on every cycle: a write or read strobe only with chip select, and never both at once; no read while the status line is high in status mode; `a0_o` high only in 8-bit mode; single-cycle valid and error pulses that exclude each other; and a rise of busy when an idle request is accepted. Several things can only be shown by the bench scenarios, because they need a converter model and counted windows. These are the exact strobe widths, the 1251-cycle timeout, the 2500-cycle watchdog, the bit placement of the sample in each width and alignment mode against junk on the unused lines, and the dropping of a request that arrives during a conversion.

// File: rtl/adc_rd_seq_pkg.sv
package adc_rd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_RD0,
    ST_RD1,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/adc_rd_cnt.sv
module adc_rd_cnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/adc_rd_asm.sv
module adc_rd_asm #(
  parameter int SAMPLE_W = 12,
  parameter int BUS_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_word_i,
  input  logic                cap_hi_i,
  input  logic                cap_lo_i,
  input  logic                align_hi_i,
  input  logic [BUS_W-1:0]    d_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int LO_W = SAMPLE_W - 8;

  logic [SAMPLE_W-1:0] word_sel;
  assign word_sel = align_hi_i ? d_i[BUS_W-1 -: SAMPLE_W] : d_i[SAMPLE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
    end else if (cap_word_i) begin
      sample_o <= word_sel;
    end else if (cap_hi_i) begin
      sample_o[SAMPLE_W-1:LO_W] <= d_i[7:0];
    end else if (cap_lo_i) begin
      // low part sits left-justified in the byte
      sample_o[LO_W-1:0] <= d_i[7 -: LO_W];
    end
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_seq_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int CONV_US     = 10,
  parameter int STROBE_CLKS = 2,
  parameter int SAMPLE_W    = 12,
  parameter int BUS_W       = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                tmo_mode_i,
  input  logic                bus8_i,
  input  logic                align_hi_i,
  input  logic                status_i,
  input  logic [BUS_W-1:0]    bus_d_i,
  output logic                cs_o,
  output logic                wr_o,
  output logic                rd_o,
  output logic                a0_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o,
  output logic                irq_o,
  output logic                busy_o,
  output logic                err_o
);
  localparam int TMO_CLKS = CLK_MHZ * CONV_US + 1;
  localparam int WDG_CLKS = 2 * CLK_MHZ * CONV_US;
  localparam int CNT_W    = $clog2(WDG_CLKS + 1);

  seq_state_e state_q, state_d;
  logic       tmo_mode_q, bus8_q, align_hi_q, seen_hi_q, err_q;
  logic       err_set, strobe_end;
  logic [CNT_W-1:0] cnt;

  adc_rd_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .cnt_o  (cnt)
  );

  assign strobe_end = (cnt == CNT_W'(STROBE_CLKS - 1));

  always_comb begin
    state_d = state_q;
    err_set = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_START;
      ST_START: if (strobe_end) state_d = ST_WAIT;
      ST_WAIT: begin
        if (tmo_mode_q) begin
          if (cnt == CNT_W'(TMO_CLKS - 1)) state_d = ST_RD0;
        end else if (seen_hi_q && !status_i) begin
          state_d = ST_RD0;
        end else if (cnt == CNT_W'(WDG_CLKS - 1)) begin
          state_d = ST_IDLE;
          err_set = 1'b1;
        end
      end
      ST_RD0:  if (strobe_end) state_d = bus8_q ? ST_RD1 : ST_DONE;
      ST_RD1:  if (strobe_end) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tmo_mode_q <= 1'b0;
      bus8_q     <= 1'b0;
      align_hi_q <= 1'b0;
      seen_hi_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_set;
      if (state_q == ST_IDLE && req_i) begin
        tmo_mode_q <= tmo_mode_i;
        bus8_q     <= bus8_i;
        align_hi_q <= align_hi_i;
      end
      if (state_q != ST_WAIT) seen_hi_q <= 1'b0;
      else if (status_i)      seen_hi_q <= 1'b1;
    end
  end

  adc_rd_asm #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_word_i (state_q == ST_RD0 && strobe_end && !bus8_q),
    .cap_hi_i   (state_q == ST_RD0 && strobe_end && bus8_q),
    .cap_lo_i   (state_q == ST_RD1 && strobe_end),
    .align_hi_i (align_hi_q),
    .d_i        (bus_d_i),
    .sample_o   (sample_o)
  );

  assign wr_o    = (state_q == ST_START);
  assign rd_o    = (state_q == ST_RD0) || (state_q == ST_RD1);
  assign cs_o    = wr_o || rd_o;
  assign a0_o    = (state_q == ST_RD1);
  assign valid_o = (state_q == ST_DONE);
  assign irq_o   = (state_q == ST_DONE);
  assign busy_o  = (state_q != ST_IDLE);
  assign err_o   = err_q;
endmodule

// File: rtl/adc_rd_seq_chk.sv
module adc_rd_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic status_i,
  input logic cs_o,
  input logic wr_o,
  input logic rd_o,
  input logic a0_o,
  input logic valid_o,
  input logic irq_o,
  input logic busy_o,
  input logic err_o,
  input logic tmo_mode_q,
  input logic bus8_q
);
  a_r1_wr_with_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> cs_o && !rd_o);
  a_r7_rd_with_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> cs_o && !wr_o);
  a_r2_no_rd_in_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && !tmo_mode_q) |-> !status_i);
  a_r5_a0_low_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a0_o |-> bus8_q && rd_o);
  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r8_irq_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> irq_o);
  a_r4_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o && !busy_o);
  a_r4_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r9_busy_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
endmodule

bind adc_rd_seq adc_rd_seq_chk u_chk (.*);

// File: tb/adc_rd_seq_bench.sv
module adc_rd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, tmo_mode = 1'b0, bus8 = 1'b0, align_hi = 1'b0;
  logic        status;
  logic [15:0] bus_d;
  logic        cs, wr, rd, a0, valid, irq, busy, err;
  logic [11:0] sample;

  int n_chk = 0, n_fail = 0;

  // converter model
  logic [11:0] code = 12'h000;
  int          conv_len = 40;
  logic        stuck = 1'b0;
  int          mcnt = 0;
  logic        mstat = 1'b0;

  // monitors
  int wr_cyc, rd_cyc, a0_cyc, valid_cyc, irq_cyc, err_cyc, gap, rd_stat;
  logic gap_on;

  always #4 clk = ~clk;

  adc_rd_seq u_adc_rd_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .tmo_mode_i(tmo_mode),
    .bus8_i(bus8), .align_hi_i(align_hi), .status_i(status), .bus_d_i(bus_d),
    .cs_o(cs), .wr_o(wr), .rd_o(rd), .a0_o(a0), .sample_o(sample),
    .valid_o(valid), .irq_o(irq), .busy_o(busy), .err_o(err)
  );

  always @(posedge clk) begin
    if (cs && wr) begin
      mstat <= 1'b1;
      mcnt  <= conv_len;
    end else if (mcnt > 0) begin
      mcnt <= mcnt - 1;
    end else if (!stuck) begin
      mstat <= 1'b0;
    end
  end
  assign status = mstat;

  // junk on every line that must be discarded
  always_comb begin
    if (!(cs && rd))   bus_d = 16'h5A5A;
    else if (bus8)     bus_d = a0 ? {8'hC3, code[3:0], 4'hB} : {8'h96, code[11:4]};
    else if (align_hi) bus_d = {code, 4'hD};
    else               bus_d = {4'hE, code};
  end

  always @(negedge clk) begin
    if (cs && wr) begin
      wr_cyc++;
      gap_on = 1'b1;
      gap = 0;
    end else if (gap_on) begin
      if (rd || err) gap_on = 1'b0;
      else gap++;
    end
    if (rd) begin
      rd_cyc++;
      if (a0) a0_cyc++;
      if (status) rd_stat++;
    end
    if (valid) valid_cyc++;
    if (irq) irq_cyc++;
    if (err) err_cyc++;
  end

  task automatic check(input logic ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic clr_mon();
    wr_cyc = 0; rd_cyc = 0; a0_cyc = 0; valid_cyc = 0; irq_cyc = 0;
    err_cyc = 0; gap = 0; rd_stat = 0; gap_on = 1'b0;
  endtask

  task automatic run(input logic tm, input logic b8, input logic ah,
                     input logic [11:0] c, input int len, input logic stk,
                     input logic extra_req);
    @(negedge clk);
    tmo_mode = tm; bus8 = b8; align_hi = ah; code = c; conv_len = len; stuck = stk;
    clr_mon();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(busy == 1'b1, "R1 busy after request", int'(busy), 1);
    if (extra_req) begin
      repeat (10) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    for (int i = 0; i < 6000; i++) begin
      if (valid_cyc > 0 || err_cyc > 0) break;
      @(negedge clk);
    end
    repeat (30) @(negedge clk);
    stuck = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!cs && !wr && !rd && !busy && !valid && !irq && !err, "R10 strobes low",
          {cs, wr, rd, busy, valid, irq, err}, 0);
    check(sample == 12'h000, "R10 sample zero", sample, 0);
  endtask

  task automatic t_status16(input logic ah, input logic [11:0] c, input int len);
    run(1'b0, 1'b0, ah, c, len, 1'b0, 1'b0);
    check(wr_cyc == 2, "R1 write strobe width", wr_cyc, 2);
    check(rd_cyc == 2 && a0_cyc == 0, "R5 single read a0 low", rd_cyc, 2);
    check(rd_cyc == 2, "R7 read strobe width", rd_cyc, 2);
    check(rd_stat == 0 && gap >= len, "R2 read after status falls", gap, len);
    check(sample == c, "R5 16-bit sample", sample, c);
    check(valid_cyc == 1 && irq_cyc == 1, "R8 valid and irq one cycle", valid_cyc, 1);
    check(err_cyc == 0 && !busy, "R1 idle after done", {err_cyc, busy}, 0);
  endtask

  task automatic t_status8(input logic [11:0] c);
    run(1'b0, 1'b1, 1'b0, c, 60, 1'b0, 1'b0);
    check(rd_cyc == 4 && a0_cyc == 2, "R6 two reads, second a0 high", rd_cyc * 16 + a0_cyc, 4 * 16 + 2);
    check(sample == c, "R6 8-bit sample", sample, c);
    check(valid_cyc == 1, "R8 single valid", valid_cyc, 1);
  endtask

  task automatic t_timeout(input logic stk, input logic [11:0] c);
    run(1'b1, 1'b0, 1'b0, c, 300, stk, 1'b0);
    check(gap == 1251, "R3 timeout wait length", gap, 1251);
    check(sample == c, "R3 sample after timeout", sample, c);
    check(err_cyc == 0, "R3 no error in timeout mode", err_cyc, 0);
  endtask

  task automatic t_watchdog();
    logic [11:0] prev;
    prev = sample;
    run(1'b0, 1'b0, 1'b0, 12'h777, 10, 1'b1, 1'b0);
    check(err_cyc == 1, "R4 one error pulse", err_cyc, 1);
    check(gap == 2500, "R4 watchdog window", gap, 2500);
    check(rd_cyc == 0 && valid_cyc == 0, "R4 no read no valid", rd_cyc + valid_cyc, 0);
    check(!busy, "R4 back to idle", int'(busy), 0);
    check(sample == prev, "R8 sample held", sample, prev);
  endtask

  task automatic t_busy_req();
    run(1'b0, 1'b1, 1'b0, 12'h5C3, 80, 1'b0, 1'b1);
    check(wr_cyc == 2, "R9 second request ignored", wr_cyc, 2);
    check(valid_cyc == 1 && sample == 12'h5C3, "R9 first sample intact", sample, 12'h5C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_status16(1'b0, 12'hABC, 50);
    t_status16(1'b1, 12'h123, 120);
    t_status8(12'h9E7);
    t_status8(12'h00F);
    t_timeout(1'b0, 12'hFFF);
    t_timeout(1'b1, 12'h801);
    t_watchdog();
    t_busy_req();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule